// File: doc/BRIEF.md
# Walsh Coefficient Multiply-Accumulate Channel

This block forms one sample of a synthesised waveform per frame. Each frame covers 32 Walsh functions. The block stores one signed 8-bit weight for each function in a small coefficient store. It steps through the functions with a 5-bit sequence index. For each function it adds the weight to a running sum when the function's current state is 1, and subtracts the weight when the state is 0. After the last function of the frame, the 13-bit sum is cut to 12 bits by dropping its least significant bit. The result is held in an output latch and the running sum restarts from zero.

The block alternates between two phases on every clock. In the host phase (`phase_o` high), a processor may write one coefficient. In the hardware phase (`phase_o` low), the block reads the weight for the current function and accumulates it. The sequence index advances once per host phase, so each function takes two clocks and a frame takes 64 clocks.

Up to ten channels share one output bus. While the upper four index bits equal this channel's number, the channel places its held sample on the bus. Otherwise it drives zero onto the bus.

Top module: `walsh_mac_channel`

## Requirements
- R1: While reset is asserted, `phase_o` is 0, `func_idx_o` is 0, `sample_o` is 0 and every stored coefficient is 0. The running sum also starts at 0.
- R2: `phase_o` inverts at every clock edge. A write (`wr_en_i`, `wr_addr_i`, `wr_data_i`) takes effect only at an edge where `phase_o` is 1. A write offered while `phase_o` is 0 leaves the store unchanged.
- R3: At each edge where `phase_o` is 1, `func_idx_o` advances by one, wrapping from 31 to 0. At every other edge it holds its value.
- R4: At each edge where `phase_o` is 0, the coefficient at index `func_idx_o` is read as 8-bit two's complement (usable range -127..+127). It is added to the running sum when `walsh_i[func_idx_o]` is 1. It is subtracted when that bit is 0.
- R5: At an edge where `phase_o` is 0 and `func_idx_o` is 31, `sample_o` takes the complete 32-term sum shifted right arithmetically by one bit. This is a floor division by 2, so a sum of -1 gives 12'hFFF. The running sum restarts at 0 for the next frame.
- R6: `sample_o` changes only at the edges named in R5. A coefficient write in mid-frame alters only the terms not yet summed in the frame in progress.
- R7: A coefficient written at a host-phase edge is the value read at any later hardware-phase edge for that index.
- R8: `bus_en_o` is 1 exactly when `func_idx_o[4:1]` equals the parameter `CHAN_ID` (a 1-of-10 channel decode). `bus_o` equals `sample_o` while `bus_en_o` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; each edge ends one phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host coefficient write request |
| wr_addr_i | input | 5 | Index of the coefficient to write |
| wr_data_i | input | 8 | Signed coefficient value |
| walsh_i | input | 32 | Current state of every Walsh function |
| phase_o | output | 1 | 1 = host phase, 0 = hardware phase |
| func_idx_o | output | 5 | Current sequence index |
| sample_o | output | 12 | Held 12-bit result of the last frame |
| bus_en_o | output | 1 | This channel owns the shared bus |
| bus_o | output | 12 | Gated sample for the shared bus |

## Verification
`phase_o` and `func_idx_o` change one clock after the edge that updates them. A write is seen by the first hardware-phase read that follows its host-phase edge. `sample_o` changes one clock after the hardware-phase edge at index 31, so a frame's result appears 64 clocks after the frame begins. `bus_en_o` follows the index within that same clock. The bench keeps a behavioural model that steps at each rising edge using the inputs held across that edge. It compares all outputs on the following falling edge, so each result is sampled in the cycle it is due.

// File: rtl/walsh_pkg.sv
package walsh_pkg;
  localparam int unsigned N_FUNC_DEF = 32;
  localparam int unsigned COEF_W_DEF = 8;
  localparam int unsigned N_CHAN_DEF = 10;

  typedef enum logic {
    PH_HW   = 1'b0,
    PH_HOST = 1'b1
  } phase_e;
endpackage

// File: rtl/walsh_seq_ctr.sv
module walsh_seq_ctr
  import walsh_pkg::*;
#(
  parameter int unsigned N_FUNC = N_FUNC_DEF,
  parameter int unsigned N_CHAN = N_CHAN_DEF,
  localparam int unsigned IDX_W = $clog2(N_FUNC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output phase_e            phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              frame_end_o,
  output logic [N_CHAN-1:0] chan_sel_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_FUNC - 1);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HW;
      idx_q   <= '0;
    end else begin
      phase_q <= (phase_q == PH_HOST) ? PH_HW : PH_HOST;
      if (phase_q == PH_HOST) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign phase_o     = phase_q;
  assign idx_o       = idx_q;
  assign frame_end_o = (phase_q == PH_HW) && (idx_q == IDX_LAST);

  // 1-of-N decode of the upper index bits
  for (genvar c = 0; c < N_CHAN; c++) begin : g_dec
    assign chan_sel_o[c] = (idx_q[IDX_W-1:1] == (IDX_W-1)'(c));
  end

  p_idx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_q) == PH_HW) |-> (idx_q == $past(idx_q)));
  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(phase_q) == PH_HOST) && ($past(idx_q) != IDX_LAST)) |-> (idx_q == $past(idx_q) + 1'b1));
  p_sel_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_sel_o));
endmodule

// File: rtl/walsh_coef_ram.sv
module walsh_coef_ram
  import walsh_pkg::*;
#(
  parameter int unsigned N_FUNC = N_FUNC_DEF,
  parameter int unsigned COEF_W = COEF_W_DEF,
  localparam int unsigned IDX_W = $clog2(N_FUNC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [COEF_W-1:0] rd_data_o
);
  logic [N_FUNC-1:0][COEF_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_en_i && phase_i == PH_HOST) mem_q[wr_addr_i] <= wr_data_i;
  end

  // hardware read port, used only in PH_HW
  assign rd_data_o = mem_q[rd_addr_i];

  p_no_write_hw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_i) == PH_HW) |-> (mem_q == $past(mem_q)));
  p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_i) == PH_HOST && $past(wr_en_i)) |-> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/walsh_term_acc.sv
module walsh_term_acc
  import walsh_pkg::*;
#(
  parameter int unsigned N_FUNC = N_FUNC_DEF,
  parameter int unsigned COEF_W = COEF_W_DEF,
  localparam int unsigned IDX_W = $clog2(N_FUNC),
  localparam int unsigned ACC_W = COEF_W + IDX_W,
  localparam int unsigned OUT_W = ACC_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              frame_end_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              wbit_i,
  output logic [OUT_W-1:0]  sample_o
);
  logic [ACC_W-1:0] acc_q, coef_ext, operand, sum_next;
  logic [OUT_W-1:0] sample_q;
  logic             cin;

  assign coef_ext = {{IDX_W{coef_i[COEF_W-1]}}, coef_i};
  // +1 passes, -1 negates via inverse plus carry-in
  assign operand  = wbit_i ? coef_ext : ~coef_ext;
  assign cin      = ~wbit_i;
  assign sum_next = acc_q + operand + {{(ACC_W-1){1'b0}}, cin};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      sample_q <= '0;
    end else if (phase_i == PH_HW) begin
      if (frame_end_i) begin
        sample_q <= sum_next[ACC_W-1:1];
        acc_q    <= '0;
      end else begin
        acc_q <= sum_next;
      end
    end
  end

  assign sample_o = sample_q;

  p_acc_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HW && frame_end_i) |=> (acc_q == '0));
  p_sample_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_i == PH_HW && frame_end_i) |=> $stable(sample_q));
  p_acc_hold_host_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HOST) |=> $stable(acc_q));
endmodule

// File: rtl/walsh_mac_channel.sv
module walsh_mac_channel
  import walsh_pkg::*;
#(
  parameter int unsigned N_FUNC  = N_FUNC_DEF,
  parameter int unsigned COEF_W  = COEF_W_DEF,
  parameter int unsigned N_CHAN  = N_CHAN_DEF,
  parameter int unsigned CHAN_ID = 0,
  localparam int unsigned IDX_W  = $clog2(N_FUNC),
  localparam int unsigned OUT_W  = COEF_W + IDX_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic [N_FUNC-1:0] walsh_i,
  output logic              phase_o,
  output logic [IDX_W-1:0]  func_idx_o,
  output logic [OUT_W-1:0]  sample_o,
  output logic              bus_en_o,
  output logic [OUT_W-1:0]  bus_o
);
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              frame_end;
  logic [N_CHAN-1:0] chan_sel;
  logic [COEF_W-1:0] coef_rd;
  logic [OUT_W-1:0]  sample;

  walsh_seq_ctr #(.N_FUNC(N_FUNC), .N_CHAN(N_CHAN)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_o     (phase),
    .idx_o       (idx),
    .frame_end_o (frame_end),
    .chan_sel_o  (chan_sel)
  );

  walsh_coef_ram #(.N_FUNC(N_FUNC), .COEF_W(COEF_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (idx),
    .rd_data_o (coef_rd)
  );

  walsh_term_acc #(.N_FUNC(N_FUNC), .COEF_W(COEF_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .frame_end_i (frame_end),
    .coef_i      (coef_rd),
    .wbit_i      (walsh_i[idx]),
    .sample_o    (sample)
  );

  assign phase_o    = (phase == PH_HOST);
  assign func_idx_o = idx;
  assign sample_o   = sample;
  assign bus_en_o   = chan_sel[CHAN_ID];
  assign bus_o      = bus_en_o ? sample : '0;

  p_bus_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_o |-> (bus_o == '0));
  p_bus_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> (bus_o == sample_o && func_idx_o[IDX_W-1:1] == (IDX_W-1)'(CHAN_ID)));
endmodule

// File: tb/walsh_mac_channel_bench.sv
module walsh_mac_channel_bench;
  localparam int CHAN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] walsh = '0;
  logic        phase;
  logic [4:0]  fidx;
  logic [11:0] sample, bus;
  logic        bus_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference
  int m_coef[32];
  int m_ph = 0, m_idx = 0, m_acc = 0, m_out = 0;

  always #5 clk = ~clk;

  walsh_mac_channel #(.CHAN_ID(CHAN)) u_walsh_mac_channel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .walsh_i(walsh), .phase_o(phase), .func_idx_o(fidx),
    .sample_o(sample), .bus_en_o(bus_en), .bus_o(bus)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 32; i++) m_coef[i] = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_ph == 1) begin
        if (wr_en) m_coef[wr_addr] = $signed(wr_data);
        m_idx = (m_idx + 1) % 32;
      end else begin
        m_acc += walsh[m_idx] ? m_coef[m_idx] : -m_coef[m_idx];
        if (m_idx == 31) begin
          m_out = m_acc >>> 1;
          m_acc = 0;
        end
      end
      m_ph ^= 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 phase", int'(phase), m_ph);
      chk("R3 index", int'(fidx), m_idx);
      chk("R5/R6 sample", int'(sample), m_out & 12'hFFF);
      chk("R8 bus_en", int'(bus_en), int'((m_idx / 2) == CHAN));
      chk("R8 bus", int'(bus), ((m_idx / 2) == CHAN) ? (m_out & 12'hFFF) : 0);
    end
  end

  task automatic host_write(input int a, input int d);
    while (phase !== 1'b1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw_phase_write(input int a, input int d);
    while (phase !== 1'b0) @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait until the start of a fresh frame (index 0, hardware phase)
  task automatic to_frame_start();
    @(negedge clk);
    while (!(fidx == 5'd0 && phase == 1'b0)) @(negedge clk);
  endtask

  task automatic run_frames(input int n);
    repeat (n) begin
      to_frame_start();
      @(negedge clk);
    end
    to_frame_start();
  endtask

  initial begin
    #1;
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset index", int'(fidx), 0);
    chk("R1 reset sample", int'(sample), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // all coefficients zero after reset: frame result 0 (R1)
    walsh = 32'hFFFF_FFFF;
    run_frames(1);
    chk("R1 empty store sum", int'(sample), 0);

    // R4/R5: all +100, all bits 1 -> 3200/2
    for (int i = 0; i < 32; i++) host_write(i, 100);
    run_frames(1);
    chk("R5 all add", int'(sample), 1600);
    // R4: all bits 0 -> subtract
    walsh = 32'h0;
    run_frames(1);
    chk("R4 all subtract", int'(sample), (-1600) & 12'hFFF);
    // extremes +/-127
    walsh = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) host_write(i, 127);
    run_frames(1);
    chk("R5 max positive", int'(sample), 2032);
    for (int i = 0; i < 32; i++) host_write(i, -127);
    run_frames(1);
    chk("R5 max negative", int'(sample), (-2032) & 12'hFFF);
    // floor rounding of dropped bit
    for (int i = 0; i < 32; i++) host_write(i, 0);
    host_write(7, -1);
    run_frames(1);
    chk("R5 floor of -1", int'(sample), 12'hFFF);
    host_write(7, 1);
    run_frames(1);
    chk("R5 floor of +1", int'(sample), 0);
    // R2: writes in hardware phase ignored
    for (int i = 0; i < 32; i++) hw_phase_write(i, 90);
    run_frames(1);
    chk("R2 ignored writes", int'(sample), 0);
    // mixed pattern, mid-frame writes (R6/R7) checked by model every cycle
    walsh = 32'hA5C3_1E69;
    for (int i = 0; i < 32; i++) host_write(i, (i * 37) % 255 - 127);
    for (int k = 0; k < 6; k++) begin
      walsh = {walsh[30:0], walsh[31] ^ walsh[21] ^ walsh[1] ^ walsh[0]};
      for (int i = 0; i < 32; i += 3) host_write(i, (i * 11 + k * 29) % 255 - 127);
    end
    run_frames(3);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule